// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Word-Granular Validity

This block sits between an instruction fetcher and a simple word-wide memory read port. It holds 256 lines of four 32-bit words. Each line has one tag entry: the upper address bits plus one "word not present" flag per word. A fetch is accepted with a valid/ready handshake. The cache then looks up the line. If the address can be cached and the addressed word is present under a matching tag, the word comes back from the data array. A fetch to a non-cacheable segment goes straight to memory and leaves the cache untouched.

On a cacheable miss the cache does not fetch the whole line. It reads only from the missed word up to the last word of the line, in ascending order, and marks the words in front of the missed word as absent. The missed word goes back to the fetcher as soon as memory returns it. The remaining words of the line keep filling in the background while the cache stays busy. After reset, a sweep of one cycle per line marks every word of every line absent before the first fetch is taken.

Top module: `fcache_top`

## Requirements
- R1: After rst_n is released, fetch_ready stays low for exactly 256 clock cycles while every line is cleared. After that no word of any line counts as present, so the first fetch to any cacheable address misses.
- R2: Address bits [11:4] select the line, bits [3:2] select the word and bits [31:12] form the tag. A fetch whose tag differs from the stored tag of its line misses, even if that word was filled under another tag.
- R3: An address is cacheable exactly when bits [31:29] hold a value of 4 or less. Values 5, 6 and 7 bypass the cache.
- R4: A bypassed fetch issues exactly one memory read carrying the fetch address unchanged and returns that word. It writes neither the tag nor the data array, so a line cached earlier at the same index still hits afterwards.
- R5: A cacheable miss on word w issues reads for words w, w+1, …, 3 of the line, in ascending order, one per request, each at {addr[31:4], word, 2'b00}. The first request is for word w.
- R6: The missed word is returned with fetch_rvalid in the cycle after its memory response. When w < 3, the fill is still running at that moment: fetch_ready stays low until the last word of the line has been written.
- R7: After a fill that started at word w, fetches of words w..3 of that line hit and fetches of words below w miss. A miss on a lower word refills from that word onward, and its flags replace the old ones.
- R8: A hit issues no memory request. fetch_rvalid is high in the second cycle after the accepting clock edge, counting that edge as the first, and fetch_rdata holds the stored word.
- R9: fetch_ready is high only when the cache is idle and no memory request is active. fetch_rvalid is a one-cycle pulse, given exactly once for each accepted fetch.
- R10: Once mem_req_valid is raised, it and mem_req_addr stay unchanged until mem_req_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request offered |
| fetch_ready | output | 1 | Cache can accept a fetch |
| fetch_addr | input | 32 | Byte address of the instruction; held until fetch_rvalid |
| fetch_rvalid | output | 1 | One-cycle strobe: fetch_rdata is valid |
| fetch_rdata | output | 32 | Returned instruction word |
| mem_req_valid | output | 1 | Memory read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Address of the word to read |
| mem_resp_valid | input | 1 | Memory read data valid |
| mem_resp_data | input | 32 | Memory read data |

## Verification
On a fill that starts below the last word, two things happen in the same cycle: the cache returns the requested word to the fetcher, and it issues the next line read while still writing the line. The bench provokes this with misses at every starting word, using a memory model whose acceptance stalls and response delay vary from cycle to cycle. At the moment of the strobe, the bench checks that fetch_ready is still low and that the returned data is the first response. Once the cache is idle again, it checks the full ascending request list. A reference model of tags and per-word flags, kept in the bench, then predicts hit or miss for later fetches to the same line. A wrong write in the middle of a fill shows up either as wrong data or as an unexpected memory request.

// File: rtl/fcache_pkg.sv
// fcache_pkg: shared state encoding and address-segment decode for the
// instruction cache. Assumes the segment code sits in the top three address bits.
package fcache_pkg;

    typedef enum logic [2:0] {
        ST_INIT,   // clearing one line per cycle after reset
        ST_IDLE,   // waiting for a fetch
        ST_LOOK,   // tag compare on the captured address
        ST_FREQ,   // offering a fill read
        ST_FRSP,   // waiting for a fill response
        ST_BREQ,   // offering a bypass read
        ST_BRSP    // waiting for a bypass response
    } fc_state_e;

    // Segment codes 0..4 are cached; 5..7 go straight to memory.
    function automatic logic fc_cacheable(input logic [2:0] seg);
        return seg <= 3'd4;
    endfunction

endpackage

// File: rtl/fcache_tag_ram.sv
// fcache_tag_ram: one tag entry per line (tag bits plus one absent flag per word).
// Combinational read, single synchronous write port. Contents are undefined
// until the controller's reset sweep has written every line.
module fcache_tag_ram #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 20,
    parameter int NWORDS = 4
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [NWORDS-1:0] rd_inv,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [NWORDS-1:0] wr_inv
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem [LINES];
    logic [NWORDS-1:0] inv_mem [LINES];

    // Write the whole entry at once.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            inv_mem[wr_idx] <= wr_inv;
        end
    end

    // Asynchronous read of the addressed entry.
    assign rd_tag = tag_mem[rd_idx];
    assign rd_inv = inv_mem[rd_idx];

endmodule

// File: rtl/fcache_data_ram.sv
// fcache_data_ram: instruction words, addressed by {line, word}.
// Combinational read, one word written per cycle. Not reset.
module fcache_data_ram #(
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] word_mem [DEPTH];

    // Store one returned fill word.
    always_ff @(posedge clk) begin
        if (wr_en) word_mem[{wr_idx, wr_word}] <= wr_data;
    end

    // Asynchronous read of the addressed word.
    assign rd_data = word_mem[{rd_idx, rd_word}];

endmodule

// File: rtl/fcache_ctrl.sv
// fcache_ctrl: sequencer for the instruction cache. It runs the reset sweep,
// takes fetches, does the tag/flag compare, drives partial-line fills and the
// bypass path, and returns words to the fetcher.
// Assumes one memory read outstanding at a time, and a fetcher that holds
// the address until fetch_rvalid.
module fcache_ctrl
    import fcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_rvalid,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [OFF_W-1:0]  rd_word,
    input  logic [ADDR_W-IDX_W-OFF_W-3:0] rd_tag,
    input  logic [(1<<OFF_W)-1:0] rd_inv,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tag_we,
    output logic [IDX_W-1:0]  tag_widx,
    output logic [ADDR_W-IDX_W-OFF_W-3:0] tag_wtag,
    output logic [(1<<OFF_W)-1:0] tag_winv,
    output logic              data_we,
    output logic [IDX_W-1:0]  data_widx,
    output logic [OFF_W-1:0]  data_wword,
    output logic [DATA_W-1:0] data_wdata
);
    localparam int NWORDS = 1 << OFF_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - 2;
    localparam int IDX_LO = OFF_W + 2;

    fc_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  word_q;
    logic [IDX_W-1:0]  init_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_word;
    logic [TAG_W-1:0]  a_tag;
    logic              a_cached;
    logic              hit;
    logic [NWORDS-1:0] fill_inv;

    // Split the captured fetch address into its fields.
    assign a_idx    = addr_q[IDX_LO +: IDX_W];
    assign a_word   = addr_q[2 +: OFF_W];
    assign a_tag    = addr_q[ADDR_W-1 -: TAG_W];
    assign a_cached = fc_cacheable(addr_q[ADDR_W-1 -: 3]);

    // A hit needs a matching tag and the addressed word's absent flag clear.
    assign hit = (rd_tag == a_tag) && !rd_inv[a_word];

    // Flags for a fill from a_word: the words in front of it are absent.
    always_comb begin
        for (int i = 0; i < NWORDS; i++) fill_inv[i] = (i < int'(a_word));
    end

    // Tag write: the sweep clears lines; a cacheable miss claims its line.
    always_comb begin
        tag_we   = 1'b0;
        tag_widx = a_idx;
        tag_wtag = a_tag;
        tag_winv = fill_inv;
        if (state_q == ST_INIT) begin
            tag_we   = 1'b1;
            tag_widx = init_q;
            tag_wtag = '0;
            tag_winv = '1;
        end else if (state_q == ST_LOOK && a_cached && !hit) begin
            tag_we = 1'b1;
        end
    end

    // Data write: each fill response lands in its word slot.
    assign data_we    = (state_q == ST_FRSP) && mem_resp_valid;
    assign data_widx  = a_idx;
    assign data_wword = word_q;
    assign data_wdata = mem_resp_data;

    // Read port follows the captured address.
    assign rd_idx  = a_idx;
    assign rd_word = a_word;

    // Memory request: a line word during a fill, the raw address for a bypass.
    assign mem_req_valid = (state_q == ST_FREQ) || (state_q == ST_BREQ);
    assign mem_req_addr  = (state_q == ST_FREQ)
                         ? {addr_q[ADDR_W-1:IDX_LO], word_q, 2'b00}
                         : addr_q;

    assign fetch_ready  = (state_q == ST_IDLE);
    assign fetch_rvalid = rvalid_q;
    assign fetch_rdata  = rdata_q;

    // Main sequencer: the sweep, lookup, fill and bypass, plus the return strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_INIT;
            init_q   <= '0;
            addr_q   <= '0;
            word_q   <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= 1'b0;
            case (state_q)
                ST_INIT: begin
                    init_q <= init_q + IDX_W'(1);
                    if (&init_q) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (fetch_valid) begin
                        addr_q  <= fetch_addr;
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (!a_cached) begin
                        state_q <= ST_BREQ;
                    end else if (hit) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= rd_data;
                        state_q  <= ST_IDLE;
                    end else begin
                        word_q  <= a_word;
                        state_q <= ST_FREQ;
                    end
                end
                ST_FREQ: begin
                    if (mem_req_ready) state_q <= ST_FRSP;
                end
                ST_FRSP: begin
                    if (mem_resp_valid) begin
                        if (word_q == a_word) begin
                            rvalid_q <= 1'b1;
                            rdata_q  <= mem_resp_data;
                        end
                        if (&word_q) begin
                            state_q <= ST_IDLE;
                        end else begin
                            word_q  <= word_q + OFF_W'(1);
                            state_q <= ST_FREQ;
                        end
                    end
                end
                ST_BREQ: begin
                    if (mem_req_ready) state_q <= ST_BRSP;
                end
                ST_BRSP: begin
                    if (mem_resp_valid) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= mem_resp_data;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_INIT;
            endcase
        end
    end

endmodule

// File: rtl/fcache_top.sv
// fcache_top: direct-mapped instruction cache with one absent flag per word
// and partial-line fills. Wires the sequencer to the tag and data arrays.
// Assumes a fetcher holding fetch_addr until fetch_rvalid, and an in-order
// memory with one read outstanding.
module fcache_top #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_rvalid,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data
);
    localparam int NWORDS = 1 << OFF_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - 2;

    logic [IDX_W-1:0]  rd_idx;
    logic [OFF_W-1:0]  rd_word;
    logic [TAG_W-1:0]  rd_tag;
    logic [NWORDS-1:0] rd_inv;
    logic [DATA_W-1:0] rd_data;
    logic              tag_we;
    logic [IDX_W-1:0]  tag_widx;
    logic [TAG_W-1:0]  tag_wtag;
    logic [NWORDS-1:0] tag_winv;
    logic              data_we;
    logic [IDX_W-1:0]  data_widx;
    logic [OFF_W-1:0]  data_wword;
    logic [DATA_W-1:0] data_wdata;

    fcache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_ready   (fetch_ready),
        .fetch_addr    (fetch_addr),
        .fetch_rvalid  (fetch_rvalid),
        .fetch_rdata   (fetch_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_resp_valid(mem_resp_valid),
        .mem_resp_data (mem_resp_data),
        .rd_idx        (rd_idx),
        .rd_word       (rd_word),
        .rd_tag        (rd_tag),
        .rd_inv        (rd_inv),
        .rd_data       (rd_data),
        .tag_we        (tag_we),
        .tag_widx      (tag_widx),
        .tag_wtag      (tag_wtag),
        .tag_winv      (tag_winv),
        .data_we       (data_we),
        .data_widx     (data_widx),
        .data_wword    (data_wword),
        .data_wdata    (data_wdata)
    );

    fcache_tag_ram #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .NWORDS(NWORDS)
    ) tag_ram_i (
        .clk   (clk),
        .rd_idx(rd_idx),
        .rd_tag(rd_tag),
        .rd_inv(rd_inv),
        .wr_en (tag_we),
        .wr_idx(tag_widx),
        .wr_tag(tag_wtag),
        .wr_inv(tag_winv)
    );

    fcache_data_ram #(
        .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
    ) data_ram_i (
        .clk    (clk),
        .rd_idx (rd_idx),
        .rd_word(rd_word),
        .rd_data(rd_data),
        .wr_en  (data_we),
        .wr_idx (data_widx),
        .wr_word(data_wword),
        .wr_data(data_wdata)
    );

endmodule

// File: rtl/fcache_chk.sv
// fcache_chk: protocol and ordering checks for fcache_top, bound below.
// Assumes the fetcher holds fetch_addr stable while a fetch is outstanding.
module fcache_chk
    import fcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_rvalid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              tag_we,
    input logic              data_we
);
    localparam int LINES  = 1 << IDX_W;
    localparam int IDX_LO = OFF_W + 2;

    logic [IDX_W:0] boot_cnt;
    logic           pending;
    logic           f_cached;

    assign f_cached = fc_cacheable(fetch_addr[ADDR_W-1 -: 3]);

    // Count cycles since reset release, saturating at the line count.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_cnt <= '0;
        else if (boot_cnt < (IDX_W+1)'(LINES)) boot_cnt <= boot_cnt + 1'b1;
    end

    // Track whether an accepted fetch still owes its return strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else if (fetch_valid && fetch_ready) pending <= 1'b1;
        else if (fetch_rvalid) pending <= 1'b0;
    end

    assert_boot_ready_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cnt < (IDX_W+1)'(LINES)) |-> !fetch_ready);

    assert_bypass_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !fetch_rvalid && mem_req_valid && !f_cached) |-> (mem_req_addr == fetch_addr));

    assert_bypass_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !fetch_rvalid && !f_cached) |-> (!tag_we && !data_we));

    assert_first_req_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !fetch_rvalid && mem_req_valid && f_cached) |->
        (mem_req_addr[ADDR_W-1:2] == fetch_addr[ADDR_W-1:2]) && (mem_req_addr[1:0] == 2'b00));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_rvalid_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rvalid |-> pending);

    assert_rvalid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rvalid |=> !fetch_rvalid);

    assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> !mem_req_valid);

endmodule

bind fcache_top fcache_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_ready  (fetch_ready),
    .fetch_addr   (fetch_addr),
    .fetch_rvalid (fetch_rvalid),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .tag_we       (tag_we),
    .data_we      (data_we)
);

// File: tb/fcache_top_tb_top.sv
`timescale 1ns/1ps
// fcache_top_tb_top: sweeps starting words, segments, aliases and a
// pseudo-random fetch stream. It predicts every hit, miss and request list
// from its own model of tags and per-word flags.
module fcache_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid;
    logic        fetch_ready;
    logic [31:0] fetch_addr;
    logic        fetch_rvalid;
    logic [31:0] fetch_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_data;

    always #2 clk = ~clk;

    fcache_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_ready   (fetch_ready),
        .fetch_addr    (fetch_addr),
        .fetch_rvalid  (fetch_rvalid),
        .fetch_rdata   (fetch_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_resp_valid(mem_resp_valid),
        .mem_resp_data (mem_resp_data)
    );

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return w ^ {w[15:0], w[31:16]} ^ 32'h6B1D_39C5;
    endfunction

    // Memory model: stalls on some cycles, answers after one or two cycles.
    int          tick = 0;
    int          req_cnt = 0;
    logic [31:0] req_log [8];
    bit          mbusy = 1'b0;
    int          mcd = 0;
    logic [31:0] maddr;
    bit          hold_prev = 1'b0;
    logic [31:0] hold_addr;

    initial begin
        mem_req_ready  = 1'b0;
        mem_resp_valid = 1'b0;
        mem_resp_data  = '0;
        forever begin
            @(negedge clk);
            tick++;
            mem_resp_valid = 1'b0;
            if (hold_prev && mem_req_valid)
                check(mem_req_addr == hold_addr, "R10 stalled request address", mem_req_addr, hold_addr);
            hold_prev = 1'b0;
            if (mbusy) begin
                mem_req_ready = 1'b0;
                mcd--;
                if (mcd == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = mem_word(maddr);
                    mbusy = 1'b0;
                end
            end else if (mem_req_valid) begin
                if (tick % 3 != 0) begin
                    mem_req_ready = 1'b1;
                    mbusy = 1'b1;
                    mcd   = 1 + (tick % 2);
                    maddr = mem_req_addr;
                    req_log[req_cnt % 8] = mem_req_addr;
                    req_cnt++;
                end else begin
                    mem_req_ready = 1'b0;
                    hold_prev = 1'b1;
                    hold_addr = mem_req_addr;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    // Reference model of tags and absent flags.
    logic [19:0] mtag [256];
    logic [3:0]  minv [256];

    task automatic run(input logic [31:0] a);
        bit          cached;
        bit          hit;
        logic [7:0]  idx;
        int          w;
        int          base;
        int          lat;
        int          nreq;
        int          guard;
        logic [31:0] got;
        bit          rdy_at;
        cached = (a[31:29] <= 3'd4);
        idx    = a[11:4];
        w      = int'(a[3:2]);
        hit    = cached && (mtag[idx] == a[31:12]) && !minv[idx][w];

        guard = 0;
        @(negedge clk); #1;
        while (!fetch_ready && guard < 5000) begin @(negedge clk); #1; guard++; end
        base        = req_cnt;
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(negedge clk); #1;
        fetch_valid = 1'b0;
        lat = 1;
        while (!fetch_rvalid && lat < 1000) begin @(negedge clk); #1; lat++; end
        got    = fetch_rdata;
        rdy_at = fetch_ready;
        @(negedge clk); #1;
        check(!fetch_rvalid, "R9 strobe lasts one cycle", 32'(fetch_rvalid), 32'd0);
        guard = 0;
        while (!fetch_ready && guard < 5000) begin @(negedge clk); #1; guard++; end
        nreq = req_cnt - base;

        check(got == mem_word(a), cached ? "R7 returned word" : "R4 bypass word", got, mem_word(a));
        if (!cached) begin
            check(nreq == 1, "R3 R4 single bypass read", 32'(nreq), 32'd1);
            check(req_log[base % 8] == a, "R4 bypass address", req_log[base % 8], a);
        end else if (hit) begin
            check(nreq == 0, "R2 R7 R8 hit issues no read", 32'(nreq), 32'd0);
            check(lat == 2, "R8 hit latency", 32'(lat), 32'd2);
        end else begin
            check(nreq == 4 - w, "R2 R5 R7 fill read count", 32'(nreq), 32'(4 - w));
            for (int j = 0; j < 4 - w && j < nreq; j++)
                check(req_log[(base + j) % 8] == {a[31:4], 2'(w + j), 2'b00}, "R5 fill order",
                      req_log[(base + j) % 8], {a[31:4], 2'(w + j), 2'b00});
            if (w < 3)
                check(!rdy_at, "R6 word returned while fill continues", 32'(rdy_at), 32'd0);
            mtag[idx] = a[31:12];
            minv[idx] = 4'((1 << w) - 1);
        end
    endtask

    initial begin
        int          n;
        logic [15:0] lfsr;
        logic [2:0]  seg;
        logic [7:0]  idx;
        logic [16:0] mid;
        for (int i = 0; i < 256; i++) begin mtag[i] = '0; minv[i] = 4'hF; end
        rst_n       = 1'b0;
        fetch_valid = 1'b0;
        fetch_addr  = '0;
        repeat (4) @(negedge clk);
        #1;
        check(!fetch_ready, "R1 ready low in reset", 32'(fetch_ready), 32'd0);
        check(!fetch_rvalid, "R9 no strobe in reset", 32'(fetch_rvalid), 32'd0);
        check(!mem_req_valid, "R9 no request in reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        n = 0;
        while (!fetch_ready && n < 1000) begin @(negedge clk); #1; n++; end
        check(n == 256, "R1 sweep length", 32'(n), 32'd256);

        // Every starting word on its own line, then every word of each line.
        for (int w = 0; w < 4; w++) run(32'h8000_0000 | 32'((w + 1) << 4) | 32'(w << 2));
        for (int w = 0; w < 4; w++)
            for (int k = 0; k < 4; k++) run(32'h8000_0000 | 32'((w + 1) << 4) | 32'(k << 2) | 32'(k));
        // Bypass aliases of a cached line, then the cached line again.
        run(32'hA000_0010);
        run(32'hC000_0014);
        run(32'hE000_001B);
        run(32'h8000_0010);
        // Same index, other tags and segments.
        run(32'h0000_0018);
        run(32'h8000_0018);
        run(32'h6000_0018);
        run(32'h8000_0FF4);
        run(32'h8000_0FF0);
        // Pseudo-random stream over a few lines, tags and segments.
        lfsr = 16'hACE1;
        for (int i = 0; i < 220; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[12:10] % 6)
                0: seg = 3'd0;
                1: seg = 3'd3;
                2: seg = 3'd4;
                3: seg = 3'd4;
                4: seg = 3'd5;
                default: seg = 3'd7;
            endcase
            case (lfsr[3:2])
                2'd0: idx = 8'h01;
                2'd1: idx = 8'h02;
                2'd2: idx = 8'h7F;
                default: idx = 8'hFF;
            endcase
            mid = lfsr[5] ? 17'h00123 : 17'h0A5C1;
            run({seg, mid, idx, lfsr[7:6], lfsr[9:8]});
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule